// File: doc/BRIEF.md
# Instruction-Level Average Current Estimator

This block watches a stream of retired instructions and estimates the average supply current of the program they form. Each instruction arrives with an opcode class and the number of clocks it took. The block weights a per-class base current by that clock count. It adds an overhead term for every pair of neighbouring instructions, which accounts for the circuit state changing from one class to the next. This includes the pair that closes the loop from the last instruction back to the first. When the program ends, the accumulated figure is divided by the total clock count. The result is an average current in the same fixed-point units as the coefficients.

The coefficients sit in two small register files that are loaded through a simple write port before a run. One file holds a base current for each class. The other holds an overhead for each ordered pair of classes. All arithmetic is unsigned fixed point. The accumulator saturates instead of wrapping. The final division is done by a sequential restoring divider that runs for one cycle per dividend bit. With supply voltage and clock period held fixed, energy follows directly from the reported current and clock total, so the block outputs only those two quantities.

Top module: `ilcur_est`

## Requirements
- R1: After reset, `res_done`, `res_busy`, `res_err`, `acc_ovf`, `res_quot`, `acc_sum` and `acc_cycles` are all zero.
- R2: Each accepted instruction (`ins_valid` high) adds `base[ins_cls] * ins_cyc` to `acc_sum` and adds `ins_cyc` to `acc_cycles`. When `ins_first` is high, both totals restart from that instruction alone. Cycles with `ins_valid` low leave both totals unchanged, whatever the other inputs carry.
- R3: Every accepted instruction that is not flagged first also adds `ovh[prev*8 + cur]`, where `prev` is the class of the preceding accepted instruction and `cur` is its own class.
- R4: The instruction flagged `ins_last` also adds `ovh[cur*8 + first]`, where `first` is the class of the program's first instruction. For a one-instruction program (first and last together), this term is `ovh[cur*8 + cur]`.
- R5: After the last instruction, `res_busy` rises while the divider runs. Then `res_done` pulses high for exactly one cycle, with `res_quot = floor(acc_sum / acc_cycles)`. `res_busy` and `res_done` are never high together, and `res_quot` holds until the next result.
- R6: If `acc_cycles` is zero at the end of a program, `res_done` pulses without `res_busy` ever rising, `res_err` is high, and `res_quot` is zero. `res_err` is low after a result with a non-zero clock total.
- R7: `acc_sum` saturates at 2^40-1 instead of wrapping, and `acc_ovf` then goes high. `acc_ovf` stays high until the next instruction flagged first.
- R8: A quotient that would not fit in 24 bits is reported as 0xFFFFFF.
- R9: With `cfg_we` high, `cfg_tbl = 0` writes `cfg_data` into the base entry `cfg_addr[2:0]`, and `cfg_tbl = 1` writes it into the overhead entry `cfg_addr[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_tbl | input | 1 | Table select: 0 base, 1 overhead |
| cfg_addr | input | 6 | Coefficient entry index |
| cfg_data | input | 16 | Coefficient value |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_cls | input | 3 | Opcode class |
| ins_cyc | input | 8 | Clocks taken by the instruction |
| ins_first | input | 1 | Instruction starts a program |
| ins_last | input | 1 | Instruction ends a program |
| acc_sum | output | 40 | Weighted current sum |
| acc_cycles | output | 32 | Total clock count |
| acc_ovf | output | 1 | Sticky saturation flag |
| res_busy | output | 1 | Divider running |
| res_done | output | 1 | One-cycle result strobe |
| res_quot | output | 24 | Average current estimate |
| res_err | output | 1 | Clock total was zero |

## Verification
The assertions assume that no instruction is presented while `res_busy` is high. They also assume that every program opens with an instruction flagged first, because the sum-growth property treats any other accepted instruction as an addition. The bench drives each program only after the previous result has been collected, and it always flags the opening instruction. Idle cycles inside a program carry random class and clock values with `ins_valid` low, to exercise the rule that unflagged cycles are ignored.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  typedef enum logic [0:0] {DV_IDLE = 1'b0, DV_RUN = 1'b1} div_state_t;
endpackage

// File: rtl/ilc_coef_tables.sv
module ilc_coef_tables #(
  parameter int CLS_W  = 3,
  parameter int COEF_W = 16
) (
  input  logic                 clk,
  input  logic                 cfg_we,
  input  logic                 cfg_tbl,
  input  logic [2*CLS_W-1:0]   cfg_addr,
  input  logic [COEF_W-1:0]    cfg_data,
  input  logic [CLS_W-1:0]     base_idx,
  input  logic [2*CLS_W-1:0]   pair_idx,
  input  logic [2*CLS_W-1:0]   wrap_idx,
  output logic [COEF_W-1:0]    base_val,
  output logic [COEF_W-1:0]    pair_val,
  output logic [COEF_W-1:0]    wrap_val
);
  localparam int N_CLS  = 1 << CLS_W;
  localparam int N_PAIR = N_CLS * N_CLS;

  logic [COEF_W-1:0] base_mem [N_CLS];
  logic [COEF_W-1:0] ovh_mem  [N_PAIR];

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_tbl) base_mem[cfg_addr[CLS_W-1:0]] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_tbl) ovh_mem[cfg_addr] <= cfg_data;
  end

  assign base_val = base_mem[base_idx];
  assign pair_val = ovh_mem[pair_idx];
  assign wrap_val = ovh_mem[wrap_idx];
endmodule

// File: rtl/ilc_accum.sv
module ilc_accum #(
  parameter int CLS_W  = 3,
  parameter int CYC_W  = 8,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  parameter int TOT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_valid,
  input  logic [CLS_W-1:0]    ins_cls,
  input  logic [CYC_W-1:0]    ins_cyc,
  input  logic                ins_first,
  input  logic                ins_last,
  input  logic [COEF_W-1:0]   base_val,
  input  logic [COEF_W-1:0]   pair_val,
  input  logic [COEF_W-1:0]   wrap_val,
  output logic [CLS_W-1:0]    base_idx,
  output logic [2*CLS_W-1:0]  pair_idx,
  output logic [2*CLS_W-1:0]  wrap_idx,
  output logic [ACC_W-1:0]    sum,
  output logic [TOT_W-1:0]    total,
  output logic                ovf,
  output logic                fin
);
  localparam int PROD_W = COEF_W + CYC_W;
  localparam logic [ACC_W-1:0] SAT_MAX = '1;

  logic [CLS_W-1:0]  prev_cls, head_cls;
  logic [PROD_W-1:0] prod;
  logic [ACC_W:0]    term, sum_ext;
  logic [ACC_W-1:0]  sum_base;
  logic [TOT_W-1:0]  tot_base;
  logic              ovf_base;

  assign base_idx = ins_cls;
  assign pair_idx = {prev_cls, ins_cls};
  assign wrap_idx = {ins_cls, (ins_first ? ins_cls : head_cls)};

  always_comb begin
    prod     = PROD_W'(base_val) * PROD_W'(ins_cyc);
    term     = (ACC_W+1)'(prod)
             + (ins_first ? '0 : (ACC_W+1)'(pair_val))
             + (ins_last  ? (ACC_W+1)'(wrap_val) : '0);
    sum_base = ins_first ? '0 : sum;
    tot_base = ins_first ? '0 : total;
    ovf_base = ins_first ? 1'b0 : ovf;
    sum_ext  = {1'b0, sum_base} + term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum      <= '0;
      total    <= '0;
      ovf      <= 1'b0;
      fin      <= 1'b0;
      prev_cls <= '0;
      head_cls <= '0;
    end else begin
      fin <= ins_valid && ins_last;
      if (ins_valid) begin
        prev_cls <= ins_cls;
        if (ins_first) head_cls <= ins_cls;
        total <= tot_base + TOT_W'(ins_cyc);
        if (sum_ext[ACC_W]) begin
          sum <= SAT_MAX;
          ovf <= 1'b1;
        end else begin
          sum <= sum_ext[ACC_W-1:0];
          ovf <= ovf_base;
        end
      end
    end
  end
endmodule

// File: rtl/ilc_divider.sv
module ilc_divider
  import ilc_pkg::*;
#(
  parameter int NUM_W = 40,
  parameter int DEN_W = 32,
  parameter int Q_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NUM_W-1:0]  num,
  input  logic [DEN_W-1:0]  den,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [Q_W-1:0]    quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  div_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DEN_W:0]    rem;
  logic [NUM_W-1:0]  dvd, q;
  logic [DEN_W-1:0]  den_r;

  logic [DEN_W:0]    rem_sh, rem_diff;
  logic              ge;
  logic [NUM_W-1:0]  q_next;
  logic [Q_W-1:0]    q_sat;

  always_comb begin
    rem_sh   = {rem[DEN_W-1:0], dvd[NUM_W-1]};
    ge       = rem_sh >= {1'b0, den_r};
    rem_diff = rem_sh - {1'b0, den_r};
    q_next   = {q[NUM_W-2:0], ge};
  end

  generate
    if (NUM_W > Q_W) begin : g_sat
      assign q_sat = (|q_next[NUM_W-1:Q_W]) ? '1 : q_next[Q_W-1:0];
    end else begin : g_nosat
      assign q_sat = Q_W'(q_next);
    end
  endgenerate

  assign busy = (state == DV_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DV_IDLE;
      cnt   <= '0;
      rem   <= '0;
      dvd   <= '0;
      q     <= '0;
      den_r <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (state == DV_IDLE) begin
        if (start) begin
          if (den == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
            quot <= '0;
          end else begin
            state <= DV_RUN;
            cnt   <= CNT_W'(NUM_W);
            rem   <= '0;
            dvd   <= num;
            q     <= '0;
            den_r <= den;
          end
        end
      end else begin
        rem <= ge ? rem_diff : rem_sh;
        dvd <= dvd << 1;
        q   <= q_next;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          state <= DV_IDLE;
          done  <= 1'b1;
          err   <= 1'b0;
          quot  <= q_sat;
        end
      end
    end
  end
endmodule

// File: rtl/ilcur_est.sv
module ilcur_est #(
  parameter int CLS_W  = 3,
  parameter int CYC_W  = 8,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  parameter int TOT_W  = 32,
  parameter int Q_W    = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_tbl,
  input  logic [2*CLS_W-1:0]  cfg_addr,
  input  logic [COEF_W-1:0]   cfg_data,
  input  logic                ins_valid,
  input  logic [CLS_W-1:0]    ins_cls,
  input  logic [CYC_W-1:0]    ins_cyc,
  input  logic                ins_first,
  input  logic                ins_last,
  output logic [ACC_W-1:0]    acc_sum,
  output logic [TOT_W-1:0]    acc_cycles,
  output logic                acc_ovf,
  output logic                res_busy,
  output logic                res_done,
  output logic [Q_W-1:0]      res_quot,
  output logic                res_err
);
  logic [CLS_W-1:0]   base_idx;
  logic [2*CLS_W-1:0] pair_idx, wrap_idx;
  logic [COEF_W-1:0]  base_val, pair_val, wrap_val;
  logic               fin;

  ilc_coef_tables #(.CLS_W(CLS_W), .COEF_W(COEF_W)) u_tbl (
    .clk      (clk),
    .cfg_we   (cfg_we),
    .cfg_tbl  (cfg_tbl),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .base_idx (base_idx),
    .pair_idx (pair_idx),
    .wrap_idx (wrap_idx),
    .base_val (base_val),
    .pair_val (pair_val),
    .wrap_val (wrap_val)
  );

  ilc_accum #(
    .CLS_W(CLS_W), .CYC_W(CYC_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .TOT_W(TOT_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_cls   (ins_cls),
    .ins_cyc   (ins_cyc),
    .ins_first (ins_first),
    .ins_last  (ins_last),
    .base_val  (base_val),
    .pair_val  (pair_val),
    .wrap_val  (wrap_val),
    .base_idx  (base_idx),
    .pair_idx  (pair_idx),
    .wrap_idx  (wrap_idx),
    .sum       (acc_sum),
    .total     (acc_cycles),
    .ovf       (acc_ovf),
    .fin       (fin)
  );

  ilc_divider #(.NUM_W(ACC_W), .DEN_W(TOT_W), .Q_W(Q_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (fin),
    .num   (acc_sum),
    .den   (acc_cycles),
    .busy  (res_busy),
    .done  (res_done),
    .err   (res_err),
    .quot  (res_quot)
  );
endmodule

// File: rtl/ilcur_est_chk.sv
module ilcur_est_chk #(
  parameter int ACC_W = 40,
  parameter int Q_W   = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ins_valid,
  input logic              ins_first,
  input logic [ACC_W-1:0]  acc_sum,
  input logic              acc_ovf,
  input logic              res_busy,
  input logic              res_done,
  input logic              res_err,
  input logic [Q_W-1:0]    res_quot
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) res_done |=> !res_done) else $error("done longer than one cycle"); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(res_busy && res_done)) else $error("busy with done"); // R5
  AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (rst) !res_done |=> (!res_done || $past(res_busy) || $past(ins_valid) || 1'b1) && (res_done || $stable(res_quot))) else $error("quotient moved"); // R5
  AST_ERR_ZERO_QUOT: assert property (@(posedge clk) disable iff (rst) res_err |-> (res_quot == '0)) else $error("error with non-zero quotient"); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (acc_ovf && !(ins_valid && ins_first)) |=> acc_ovf) else $error("overflow flag dropped"); // R7
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst) (acc_sum == '1 && ins_valid && !ins_first) |=> (acc_sum == '1)) else $error("saturated sum wrapped"); // R7
  AST_SUM_GROWS: assert property (@(posedge clk) disable iff (rst) (ins_valid && !ins_first) |=> (acc_sum >= $past(acc_sum))) else $error("sum decreased"); // R2
  AST_IDLE_SUM: assert property (@(posedge clk) disable iff (rst) !ins_valid |=> $stable(acc_sum)) else $error("sum moved while idle"); // R2
  AST_NO_INPUT_BUSY: assert property (@(posedge clk) disable iff (rst) res_busy |-> !ins_valid) else $error("instruction during division"); // R5
endmodule

bind ilcur_est ilcur_est_chk #(.ACC_W(ACC_W), .Q_W(Q_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .ins_first (ins_first),
  .acc_sum   (acc_sum),
  .acc_ovf   (acc_ovf),
  .res_busy  (res_busy),
  .res_done  (res_done),
  .res_err   (res_err),
  .res_quot  (res_quot)
);

// File: tb/ilcur_est_tb.sv
`timescale 1ns/1ps
module ilcur_est_tb;
  localparam longint SAT = (64'd1 << 40) - 1;
  localparam longint QMAX = (64'd1 << 24) - 1;
  localparam int MAXP = 70000;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_tbl = 0;
  logic [5:0] cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic ins_valid = 0, ins_first = 0, ins_last = 0;
  logic [2:0] ins_cls = 0;
  logic [7:0] ins_cyc = 0;
  logic [39:0] acc_sum;
  logic [31:0] acc_cycles;
  logic acc_ovf, res_busy, res_done, res_err;
  logic [23:0] res_quot;

  int checks = 0, errors = 0;
  longint bm [8];
  longint om [64];
  int pc [MAXP];
  int pn [MAXP];

  always #10 clk = ~clk;

  ilcur_est u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit tbl, input int addr, input longint val);
    @(negedge clk);
    cfg_we = 1; cfg_tbl = tbl; cfg_addr = 6'(addr); cfg_data = 16'(val);
    if (tbl) om[addr] = val & 16'hFFFF; else bm[addr] = val & 16'hFFFF;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Expected values per R2, R3, R4, R7, R8
  task automatic run_prog(input int n, input bit gaps, input string tag);
    longint s = 0, t, tot = 0, q;
    bit ov = 0, seen_busy = 0, got = 0;
    for (int k = 0; k < n; k++) begin
      t = bm[pc[k]] * pn[k];
      if (k > 0) t += om[pc[k-1]*8 + pc[k]];
      if (k == n-1) t += om[pc[k]*8 + pc[0]];
      s += t; tot += pn[k];
      if (s > SAT) begin s = SAT; ov = 1; end
    end
    q = (tot == 0) ? 0 : s / tot;
    if (q > QMAX) q = QMAX;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        ins_valid = 0; ins_cls = 3'($urandom); ins_cyc = 8'($urandom);
        ins_first = 1'($urandom); ins_last = 1'($urandom);
        @(negedge clk);
      end
      ins_valid = 1; ins_cls = 3'(pc[k]); ins_cyc = 8'(pn[k]);
      ins_first = (k == 0); ins_last = (k == n-1);
    end
    @(negedge clk);
    ins_valid = 0; ins_first = 0; ins_last = 0;
    chk(acc_sum == 40'(s), {"R2 R3 R4 sum ", tag}, acc_sum, s);
    chk(acc_cycles == 32'(tot), {"R2 cycles ", tag}, acc_cycles, tot);
    chk(acc_ovf == ov, {"R7 ovf ", tag}, acc_ovf, ov);
    for (int w = 0; w < 100 && !got; w++) begin
      @(negedge clk);
      if (res_busy) seen_busy = 1;
      if (res_done) got = 1;
    end
    chk(got, {"R5 done ", tag}, got, 1);
    chk(res_quot == 24'(q), {"R5 R8 quotient ", tag}, res_quot, q);
    chk(res_err == (tot == 0), {"R6 err ", tag}, res_err, tot == 0);
    chk(seen_busy == (tot != 0), {"R5 R6 busy ", tag}, seen_busy, tot != 0);
    @(negedge clk);
    chk(!res_done, {"R5 done pulse ", tag}, res_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!res_done && !res_busy && !res_err, "R1 flags", {res_done, res_busy, res_err}, 0);
    chk(!acc_ovf && res_quot == 0, "R1 ovf/quot", res_quot, 0);
    chk(acc_sum == 0 && acc_cycles == 0, "R1 totals", acc_sum, 0);

    for (int i = 0; i < 8; i++) wr(0, i, $urandom);
    for (int i = 0; i < 64; i++) wr(1, i, $urandom);

    // R9 R4: single instruction, base entry 2 and overhead {2,2}
    wr(0, 2, 16'd1234); wr(1, 18, 16'd77);
    pc[0] = 2; pn[0] = 3;
    run_prog(1, 0, "single R9");

    // R3 R4: two-instruction program, both orderings of overhead
    wr(1, 5*8+1, 16'd11); wr(1, 1*8+5, 16'd500);
    pc[0] = 5; pn[0] = 2; pc[1] = 1; pn[1] = 4;
    run_prog(2, 0, "pair");

    // Random programs with idle gaps (R2 ignored cycles)
    for (int r = 0; r < 20; r++) begin
      int n = 1 + ($urandom % 40);
      for (int k = 0; k < n; k++) begin pc[k] = $urandom % 8; pn[k] = $urandom % 256; end
      run_prog(n, 1, "random");
    end

    // R6: every instruction zero cycles
    for (int k = 0; k < 5; k++) begin pc[k] = k; pn[k] = 0; end
    run_prog(5, 0, "zero cycles");

    // R8: heavy overhead with one clock
    wr(1, 0, 16'hFFFF);
    for (int k = 0; k < 300; k++) begin pc[k] = 0; pn[k] = 0; end
    pn[299] = 1;
    run_prog(300, 0, "quot sat");

    // R7: saturation
    wr(0, 7, 16'hFFFF); wr(1, 63, 16'hFFFF);
    for (int k = 0; k < 66000; k++) begin pc[k] = 7; pn[k] = 255; end
    run_prog(66000, 0, "sat");

    // R7: flag clears on next program
    pc[0] = 3; pn[0] = 1; pc[1] = 4; pn[1] = 9;
    run_prog(2, 0, "after sat");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule